// File: doc/BRIEF.md
# Fixed-Point Radix-2 Complex Butterfly

This block is the arithmetic core of a decimation-in-time FFT stage. Each accepted transfer carries a top complex sample, a bottom complex sample and one twiddle value given as a cosine and a sine. The block returns two complex results. The sum output is the top sample plus the rotated bottom sample, and the difference output is the top sample minus it. All values are 16-bit signed fractions with 15 fraction bits. The rotated bottom sample is computed once and feeds both outputs.

Three per-transfer control bits travel with each sample through the pipe:
- **Pre-scale** halves both input samples before any arithmetic, which leaves headroom across many stages.
- **Unity** skips the multiplier for the zero-angle twiddle. In that case the twiddle inputs have no effect.
- **Post-scale** doubles both results on the way out, which undoes an earlier pre-scale.

The pipe is three registers deep. It accepts one butterfly per cycle and stalls as a whole when the consumer withholds ready.

The block does not store or address twiddles and does not sequence FFT stages. The surrounding controller does that.

Top module: `cplx_bfly_r2`

## Requirements
- R1: With pre-scale, unity and post-scale all clear, sum = top + P and difference = top − P. Here P_re = (b_re·cos + b_im·sin) >>> 15 and P_im = (b_im·cos − b_re·sin) >>> 15, and the same P is used for both outputs.
- R2: The narrowing of each 32-bit product sum is an arithmetic right shift by 15, which rounds toward minus infinity. For example, b_re = −1 and cos = 1 give P_re = −1.
- R3: After the shift, each product part saturates to [−32768, 32767]. For example, all four multiplier operands at −32768 give P_re = 32767.
- R4: The final add and subtract saturate to [−32768, 32767] and do not wrap.
- R5: When in_prescale is 1, the top and bottom samples are both shifted right arithmetically by 1 before the multiply and the add. The twiddle is not shifted.
- R6: When in_postscale is 1, each saturated result is shifted left by 1, keeping the low 16 bits. Bit 0 of every output is then 0.
- R7: When in_unity is 1, P equals the (possibly pre-scaled) bottom sample, and the cosine and sine inputs have no effect.
- R8: A result appears on the outputs exactly 3 clock edges after its input is accepted. With out_ready held at 1, one result leaves every cycle.
- R9: While out_valid is 1 and out_ready is 0, the outputs hold their values and in_ready is 0. No transfer is lost or duplicated.
- R10: A synchronous active-low reset clears all pending results: out_valid is 0 and in_ready is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Pipe can take an input this cycle |
| in_top_re | input | 16 | Top sample, real part |
| in_top_im | input | 16 | Top sample, imaginary part |
| in_bot_re | input | 16 | Bottom sample, real part |
| in_bot_im | input | 16 | Bottom sample, imaginary part |
| in_cos | input | 16 | Twiddle cosine |
| in_sin | input | 16 | Twiddle sine |
| in_prescale | input | 1 | Halve both input samples |
| in_unity | input | 1 | Bypass the multiply |
| in_postscale | input | 1 | Double both results |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_sum_re | output | 16 | Sum output, real part |
| out_sum_im | output | 16 | Sum output, imaginary part |
| out_dif_re | output | 16 | Difference output, real part |
| out_dif_im | output | 16 | Difference output, imaginary part |

## Verification
Two situations are hard to reach from the ports.

The first is product saturation. Only the case where both bottom parts and both twiddle parts are −32768 drives the product sum to +2^31. A fixed vector in the stimulus table targets it, and random vectors are biased toward the two extreme values.

The second is back-pressure arriving while all three stages hold live data. The bench streams the whole vector set twice. The first pass keeps out_ready high and checks for a gap-free output stream. The second pass drops out_ready for two of every five cycles while in_valid stays high, so stalls land on a full pipe. In both passes every result is matched in order against a bit-exact integer model.

// File: rtl/bfly_pkg.sv
// Shared definitions for the radix-2 butterfly datapath.
// Assumes: per-sample control bits travel alongside the data through the pipe.
package bfly_pkg;

    // Default sample width (signed fraction, DW-1 fraction bits)
    localparam int unsigned BFLY_DW = 16;

    // Control bits that must stay aligned with their sample after stage 1
    typedef struct packed {
        logic unity;   // skip the multiply
        logic post;    // double results at the output
    } bfly_mode_t;

endpackage

// File: rtl/bfly_cmul.sv
// Stage 2: forms the rotated bottom sample P = bottom * conj-rotation by
// (cos, sin), truncates it by an arithmetic right shift of DW-1 and saturates
// it back to DW bits. In unity mode the bottom sample passes through.
// Assumes: en stalls the stage; valid is reset, data registers are not.
module bfly_cmul #(
    parameter int unsigned DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 v_i,
    input  bfly_pkg::bfly_mode_t mode_i,
    input  logic signed [DW-1:0] t_re_i,
    input  logic signed [DW-1:0] t_im_i,
    input  logic signed [DW-1:0] b_re_i,
    input  logic signed [DW-1:0] b_im_i,
    input  logic signed [DW-1:0] cos_i,
    input  logic signed [DW-1:0] sin_i,
    output logic                 v_o,
    output logic                 post_o,
    output logic signed [DW-1:0] t_re_o,
    output logic signed [DW-1:0] t_im_o,
    output logic signed [DW-1:0] p_re_o,
    output logic signed [DW-1:0] p_im_o
);
    localparam int unsigned PW = 2 * DW + 1;
    localparam int unsigned FB = DW - 1;
    localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0] bre_x, bim_x, cos_x, sin_x;
    logic signed [PW-1:0] acc_re, acc_im, sh_re, sh_im;
    logic signed [DW-1:0] nar_re, nar_im;

    // Clamp a wide value into the DW-bit signed range
    function automatic logic signed [DW-1:0] clamp(input logic signed [PW-1:0] x);
        if (x > MAXV)      return MAXV[DW-1:0];
        else if (x < MINV) return MINV[DW-1:0];
        else               return x[DW-1:0];
    endfunction

    // Widen operands, multiply-accumulate, truncate and saturate
    always_comb begin
        bre_x  = PW'(b_re_i);
        bim_x  = PW'(b_im_i);
        cos_x  = PW'(cos_i);
        sin_x  = PW'(sin_i);
        acc_re = bre_x * cos_x + bim_x * sin_x;
        acc_im = bim_x * cos_x - bre_x * sin_x;
        sh_re  = acc_re >>> FB;
        sh_im  = acc_im >>> FB;
        nar_re = clamp(sh_re);
        nar_im = clamp(sh_im);
    end

    // Valid bit of stage 2
    always_ff @(posedge clk) begin
        if (!rst_n)  v_o <= 1'b0;
        else if (en) v_o <= v_i;
    end

    // Data registers of stage 2; unity mode forwards the bottom sample
    always_ff @(posedge clk) begin
        if (en) begin
            post_o <= mode_i.post;
            t_re_o <= t_re_i;
            t_im_o <= t_im_i;
            p_re_o <= mode_i.unity ? b_re_i : nar_re;
            p_im_o <= mode_i.unity ? b_im_i : nar_im;
        end
    end

    // R7: in unity mode the registered product is the bottom sample
    assert_unity_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && v_i && mode_i.unity) |=> (p_re_o == $past(b_re_i) && p_im_o == $past(b_im_i)));

    // R3: the full-scale negative corner clamps to the positive limit
    assert_prod_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && v_i && !mode_i.unity && b_re_i == MINV[DW-1:0] && b_im_i == MINV[DW-1:0]
         && cos_i == MINV[DW-1:0] && sin_i == MINV[DW-1:0]) |=> (p_re_o == MAXV[DW-1:0]));
endmodule

// File: rtl/bfly_addsub.sv
// Stage 3: saturating sum and difference of the top sample and P, followed
// by the optional left shift by one (low DW bits kept).
// Assumes: en stalls the stage; outputs are the block's output registers.
module bfly_addsub #(
    parameter int unsigned DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 v_i,
    input  logic                 post_i,
    input  logic signed [DW-1:0] t_re_i,
    input  logic signed [DW-1:0] t_im_i,
    input  logic signed [DW-1:0] p_re_i,
    input  logic signed [DW-1:0] p_im_i,
    output logic                 v_o,
    output logic signed [DW-1:0] s_re_o,
    output logic signed [DW-1:0] s_im_o,
    output logic signed [DW-1:0] d_re_o,
    output logic signed [DW-1:0] d_im_o
);
    localparam int unsigned SW = DW + 1;
    localparam logic signed [SW-1:0] MAXV = {2'b00, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] MINV = {2'b11, {(DW-1){1'b0}}};

    logic signed [SW-1:0] sum_re, sum_im, dif_re, dif_im;
    logic signed [DW-1:0] ss_re, ss_im, sd_re, sd_im;

    // Clamp a DW+1 bit value into DW bits
    function automatic logic signed [DW-1:0] clamp(input logic signed [SW-1:0] x);
        if (x > MAXV)      return MAXV[DW-1:0];
        else if (x < MINV) return MINV[DW-1:0];
        else               return x[DW-1:0];
    endfunction

    // Optional doubling, keeping the low DW bits
    function automatic logic signed [DW-1:0] dbl(input logic signed [DW-1:0] x, input logic on);
        return on ? {x[DW-2:0], 1'b0} : x;
    endfunction

    // Widened add/subtract and saturation
    always_comb begin
        sum_re = SW'(t_re_i) + SW'(p_re_i);
        sum_im = SW'(t_im_i) + SW'(p_im_i);
        dif_re = SW'(t_re_i) - SW'(p_re_i);
        dif_im = SW'(t_im_i) - SW'(p_im_i);
        ss_re  = clamp(sum_re);
        ss_im  = clamp(sum_im);
        sd_re  = clamp(dif_re);
        sd_im  = clamp(dif_im);
    end

    // Output valid bit
    always_ff @(posedge clk) begin
        if (!rst_n)  v_o <= 1'b0;
        else if (en) v_o <= v_i;
    end

    // Output data registers
    always_ff @(posedge clk) begin
        if (en) begin
            s_re_o <= dbl(ss_re, post_i);
            s_im_o <= dbl(ss_im, post_i);
            d_re_o <= dbl(sd_re, post_i);
            d_im_o <= dbl(sd_im, post_i);
        end
    end

    // R4: two non-negative operands never produce a negative sum
    assert_sum_nowrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && v_i && !post_i && !t_re_i[DW-1] && !p_re_i[DW-1]) |=> !s_re_o[DW-1]);

    // R6: doubled results always have a clear bit 0
    assert_post_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && v_i && post_i) |=> (!s_re_o[0] && !s_im_o[0] && !d_re_o[0] && !d_im_o[0]));
endmodule

// File: rtl/cplx_bfly_r2.sv
// Radix-2 DIT complex butterfly, three-stage pipe with a global stall.
// Stage 1 registers the (optionally halved) samples, twiddle and mode;
// stage 2 forms the shared product; stage 3 adds, subtracts and scales.
// Assumes: the whole pipe advances when the output register is empty or drained.
module cplx_bfly_r2 #(
    parameter int unsigned DW = bfly_pkg::BFLY_DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] in_top_re,
    input  logic signed [DW-1:0] in_top_im,
    input  logic signed [DW-1:0] in_bot_re,
    input  logic signed [DW-1:0] in_bot_im,
    input  logic signed [DW-1:0] in_cos,
    input  logic signed [DW-1:0] in_sin,
    input  logic                 in_prescale,
    input  logic                 in_unity,
    input  logic                 in_postscale,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [DW-1:0] out_sum_re,
    output logic signed [DW-1:0] out_sum_im,
    output logic signed [DW-1:0] out_dif_re,
    output logic signed [DW-1:0] out_dif_im
);
    import bfly_pkg::*;

    logic                 adv;
    logic                 v1, v2, post2;
    bfly_mode_t           m1;
    logic signed [DW-1:0] t1_re, t1_im, b1_re, b1_im, c1, s1;
    logic signed [DW-1:0] t2_re, t2_im, p2_re, p2_im;

    // Global advance: the pipe moves unless a result is waiting unaccepted
    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    // Stage 1 valid bit
    always_ff @(posedge clk) begin
        if (!rst_n)   v1 <= 1'b0;
        else if (adv) v1 <= in_valid;
    end

    // Stage 1 data, with optional halving of both samples
    always_ff @(posedge clk) begin
        if (adv) begin
            t1_re    <= in_prescale ? (in_top_re >>> 1) : in_top_re;
            t1_im    <= in_prescale ? (in_top_im >>> 1) : in_top_im;
            b1_re    <= in_prescale ? (in_bot_re >>> 1) : in_bot_re;
            b1_im    <= in_prescale ? (in_bot_im >>> 1) : in_bot_im;
            c1       <= in_cos;
            s1       <= in_sin;
            m1.unity <= in_unity;
            m1.post  <= in_postscale;
        end
    end

    bfly_cmul #(.DW(DW)) u_cmul (
        .clk(clk), .rst_n(rst_n), .en(adv), .v_i(v1), .mode_i(m1),
        .t_re_i(t1_re), .t_im_i(t1_im), .b_re_i(b1_re), .b_im_i(b1_im),
        .cos_i(c1), .sin_i(s1),
        .v_o(v2), .post_o(post2), .t_re_o(t2_re), .t_im_o(t2_im),
        .p_re_o(p2_re), .p_im_o(p2_im)
    );

    bfly_addsub #(.DW(DW)) u_addsub (
        .clk(clk), .rst_n(rst_n), .en(adv), .v_i(v2), .post_i(post2),
        .t_re_i(t2_re), .t_im_i(t2_im), .p_re_i(p2_re), .p_im_i(p2_im),
        .v_o(out_valid), .s_re_o(out_sum_re), .s_im_o(out_sum_im),
        .d_re_o(out_dif_re), .d_im_o(out_dif_im)
    );

    // R9: a refused result stays put
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sum_re) && $stable(out_sum_im)
                                       && $stable(out_dif_re) && $stable(out_dif_im)));

    // R9: no input is taken while a result is refused
    assert_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/cplx_bfly_r2_tb_top.sv
`timescale 1ns/1ps
module cplx_bfly_r2_tb_top;
    localparam int NV = 64;
    localparam int NT = 12;

    // Directed stimulus: top re, top im, bot re, bot im, cos, sin
    localparam logic [15:0] TBL [NT][6] = '{
        '{16'd1000,  16'd2000,  16'd3000,  16'hF060, 16'h4000, 16'h0000},
        '{16'h0000,  16'h0000,  16'hFFFF,  16'h0000, 16'h0001, 16'h0000},
        '{16'h0000,  16'h0000,  16'h8000,  16'h8000, 16'h8000, 16'h8000},
        '{16'h7FFF,  16'h7FFF,  16'h7FFF,  16'h7FFF, 16'h7FFF, 16'h0000},
        '{16'h8000,  16'h8000,  16'h7FFF,  16'h7FFF, 16'h7FFF, 16'h0000},
        '{16'h7FFF,  16'h8000,  16'h7FFF,  16'h8000, 16'd1234, 16'd5678},
        '{16'd12345, 16'hFF22,  16'hE4A8,  16'd333,  16'hFFFF, 16'hFFFF},
        '{16'd100,   16'hFF9C,  16'd50,    16'd25,   16'h0000, 16'h0000},
        '{16'd20000, 16'd20000, 16'd20000, 16'd20000,16'h0000, 16'h0000},
        '{16'd5,     16'd7,     16'd23170, 16'd23170,16'd23170,16'hA57E},
        '{16'h8000,  16'h7FFF,  16'h8000,  16'h7FFF, 16'h8000, 16'h7FFF},
        '{16'd3,     16'hFFFD,  16'hFFFD,  16'd3,    16'h7FFF, 16'h7FFF}
    };
    // Mode per directed vector: {prescale, unity, postscale}
    localparam logic [2:0] TMODE [NT] = '{
        3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b100,
        3'b010, 3'b001, 3'b111, 3'b000, 3'b000, 3'b001
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
    logic signed [15:0] in_top_re = '0, in_top_im = '0, in_bot_re = '0, in_bot_im = '0;
    logic signed [15:0] in_cos = '0, in_sin = '0;
    logic in_prescale = 1'b0, in_unity = 1'b0, in_postscale = 1'b0;
    logic signed [15:0] out_sum_re, out_sum_im, out_dif_re, out_dif_im;

    int nchk = 0, nerr = 0;
    int vtr[NV], vti[NV], vbr[NV], vbi[NV], vc[NV], vs[NV];
    bit vpre[NV], vuni[NV], vpost[NV];
    logic [63:0] vexp[NV];
    string vtag[NV];

    always #2 clk = ~clk;

    cplx_bfly_r2 dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_top_re(in_top_re), .in_top_im(in_top_im), .in_bot_re(in_bot_re),
        .in_bot_im(in_bot_im), .in_cos(in_cos), .in_sin(in_sin),
        .in_prescale(in_prescale), .in_unity(in_unity), .in_postscale(in_postscale),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_sum_re(out_sum_re), .out_sum_im(out_sum_im),
        .out_dif_re(out_dif_re), .out_dif_im(out_dif_im)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic longint sat16(input longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    // Bit-exact model built from the requirements
    function automatic logic [63:0] model(input int i);
        longint tr, ti, br, bi, pr, pi, sr, si, dr, di;
        tr = vtr[i]; ti = vti[i]; br = vbr[i]; bi = vbi[i];
        if (vpre[i]) begin tr = tr >>> 1; ti = ti >>> 1; br = br >>> 1; bi = bi >>> 1; end
        if (vuni[i]) begin pr = br; pi = bi; end
        else begin
            pr = sat16((br * vc[i] + bi * vs[i]) >>> 15);
            pi = sat16((bi * vc[i] - br * vs[i]) >>> 15);
        end
        sr = sat16(tr + pr); si = sat16(ti + pi);
        dr = sat16(tr - pr); di = sat16(ti - pi);
        if (vpost[i]) begin sr = sr * 2; si = si * 2; dr = dr * 2; di = di * 2; end
        return {16'(sr), 16'(si), 16'(dr), 16'(di)};
    endfunction

    function automatic int pick();
        int unsigned r = $urandom;
        case (r % 4)
            0: return -32768;
            1: return 32767;
            default: return int'($signed(r[31:16]));
        endcase
    endfunction

    task automatic drive(input int i);
        in_top_re = 16'(vtr[i]); in_top_im = 16'(vti[i]);
        in_bot_re = 16'(vbr[i]); in_bot_im = 16'(vbi[i]);
        in_cos = 16'(vc[i]); in_sin = 16'(vs[i]);
        in_prescale = vpre[i]; in_unity = vuni[i]; in_postscale = vpost[i];
    endtask

    function automatic logic [63:0] outs();
        return {out_sum_re, out_sum_im, out_dif_re, out_dif_im};
    endfunction

    // Stream all vectors; optionally withhold out_ready two cycles in five
    task automatic run_stream(input bit stall);
        int wr = 0, rd = 0, cyc = 0;
        bit held = 0, gap = 0, started = 0;
        logic [63:0] hv = '0;
        while (rd < NV && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            out_ready = stall ? ((cyc % 5) >= 2) : 1'b1;
            #1;
            if (held) chk(out_valid && outs() == hv, "R9 hold", outs(), hv);
            held = 0;
            if (out_valid) started = 1;
            else if (started && !stall) gap = 1;
            if (out_valid && out_ready) begin
                chk(outs() == vexp[rd], vtag[rd], outs(), vexp[rd]);
                rd++;
            end else if (out_valid) begin
                held = 1;
                hv = outs();
                chk(!in_ready, "R9 in_ready", 64'(in_ready), 64'd0);
            end
            if (wr < NV) begin
                drive(wr);
                in_valid = 1'b1;
                if (in_ready) wr++;
            end else in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        if (!stall) chk(!gap, "R8 throughput", 64'(gap), 64'd0);
        chk(rd == NV, "R9 count", 64'(rd), 64'(NV));
        repeat (4) @(negedge clk);
        chk(!out_valid, "R9 no duplicate", 64'(out_valid), 64'd0);
    endtask

    initial begin
        #(4 * 200000);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int lat;
        // Build the vector set
        for (int i = 0; i < NV; i++) begin
            if (i < NT) begin
                vtr[i] = int'($signed(TBL[i][0])); vti[i] = int'($signed(TBL[i][1]));
                vbr[i] = int'($signed(TBL[i][2])); vbi[i] = int'($signed(TBL[i][3]));
                vc[i]  = int'($signed(TBL[i][4])); vs[i]  = int'($signed(TBL[i][5]));
                {vpre[i], vuni[i], vpost[i]} = TMODE[i];
            end else begin
                vtr[i] = pick(); vti[i] = pick(); vbr[i] = pick(); vbi[i] = pick();
                vc[i] = pick(); vs[i] = pick();
                vpre[i] = ($urandom % 3) == 0; vuni[i] = ($urandom % 4) == 0;
                vpost[i] = ($urandom % 3) == 0;
            end
            vexp[i] = model(i);
        end
        vtag = '{default: "R1 random"};
        vtag[0] = "R1 basic"; vtag[1] = "R2 truncation"; vtag[2] = "R3 product sat";
        vtag[3] = "R4 sum sat"; vtag[4] = "R4 diff sat"; vtag[5] = "R5 prescale";
        vtag[6] = "R7 unity ignores twiddle"; vtag[7] = "R6 postscale";
        vtag[8] = "R5 R6 R7 combined"; vtag[9] = "R1 rotation";
        vtag[10] = "R3 extremes"; vtag[11] = "R6 postscale lsb";

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!out_valid, "R10 out_valid in reset", 64'(out_valid), 64'd0);
        chk(in_ready, "R10 in_ready in reset", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R10 out_valid after reset", 64'(out_valid), 64'd0);

        // Main function, no stall then with stalls
        run_stream(1'b0);
        run_stream(1'b1);

        // R8: latency of a single transfer into an idle pipe
        @(negedge clk);
        drive(0);
        in_valid = 1'b1;
        lat = 0;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 3, "R8 latency", 64'(lat), 64'd3);
        chk(outs() == vexp[0], "R8 latency data", outs(), vexp[0]);

        // R10: reset discards pending work
        @(negedge clk);
        drive(3);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(!out_valid, "R10 flush", 64'(out_valid), 64'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule